// File: doc/BRIEF.md
# Fast-Lock Bandwidth Window Timer

This block times the short wide-bandwidth interval that a synthesizer's loop uses right after it is retuned. Configuration software selects one of four divider modes. In the fast-lock mode, every write to the integer/fractional divider register opens a window. The window is counted in phase-detector cycles, which reach the block as a one-cycle enable strobe on the system clock. While the window is open, the block forces the charge-pump current code to full scale. It also closes an analog switch that bypasses part of the loop-filter shunt resistance, provided the multiplexed-pin select is set to the switch function. When the count runs out, the programmed pump code returns and a one-cycle done pulse is raised.

The block has one 12-bit down counter, and the window is one of its users. In the two free-running modes (phase adjust and converter clock), the same counter reloads itself every time it reaches terminal count. It then emits a periodic tick that the neighbouring logic consumes. A zero window length is illegal: a start request with that length is refused and a sticky error flag is raised.

Top module: `fastlock_timer`

## Requirements
- R1: After reset, `win_active`, `filt_short`, `win_done`, `div_tc` and `len_err` are 0, and `cp_code_eff` equals `cp_prog`.
- R2: When `mode_sel` is 2'b01 and `reg0_wr` is high at a clock edge with `win_len` nonzero, a window opens from that edge. While the window is open, `win_active` is 1 and `cp_code_eff` is 4'b1111 regardless of `cp_prog`.
- R3: A window closes at the clock edge that samples the `win_len`-th high `pfd_tick` after the opening edge. A tick in the opening cycle itself is not counted.
- R4: At the edge where a window closes by count, `cp_code_eff` returns to `cp_prog`, and `win_done` goes high for exactly one clock.
- R5: `filt_short` is 1 exactly when a window is open and `mux_cfg` equals 4'b1100.
- R6: A qualifying `reg0_wr` while a window is open restarts the count from the current `win_len` and produces no done pulse.
- R7: A `reg0_wr` in mode 2'b01 with `win_len` of 0 opens no window and sets `len_err`. An open window continues. `len_err` stays set until a window is accepted.
- R8: In modes 2'b00, 2'b10 and 2'b11, `reg0_wr` has no effect. Leaving mode 2'b01 closes an open window at the next edge without a done pulse.
- R9: In modes 2'b10 and 2'b11, the counter loads `win_len` on mode entry, or whenever it sits at zero. `div_tc` pulses for one clock each time `win_len` ticks have counted down, and then the counter reloads. With `win_len` of 0 there is no `div_tc`.
- R10: `div_tc` never rises in modes 2'b00 and 2'b01, and `win_done` never rises outside mode 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pfd_tick | input | 1 | One-clock strobe per phase-detector cycle |
| mode_sel | input | 2 | Divider mode: 00 off, 01 fast lock, 10 phase adjust, 11 converter clock |
| reg0_wr | input | 1 | Pulse on each write to the divider register |
| win_len | input | 12 | Window length / tick period in phase-detector cycles |
| cp_prog | input | 4 | Programmed charge-pump current code |
| mux_cfg | input | 4 | Multiplexed-pin select; 4'b1100 enables the filter switch |
| cp_code_eff | output | 4 | Charge-pump code actually applied |
| filt_short | output | 1 | Loop-filter resistor bypass switch enable |
| win_active | output | 1 | Wide-bandwidth window open |
| win_done | output | 1 | One-clock pulse when a window expires |
| div_tc | output | 1 | Terminal-count tick in free-running modes |
| len_err | output | 1 | Sticky flag: start refused because length was 0 |

## Verification
The bench builds the block with its default 12-bit counter and 4-bit code fields. This allows short random window lengths, where restarts, coincident ticks and mode changes happen often. It also allows one directed window of the full 4095 cycles, which exercises the top of the counter range. The phase-detector strobe is randomized, so that uncounted ticks in the opening cycle and long gaps between ticks are both covered. Zero lengths are mixed into the fast-lock and free-running phases to exercise the refusal and stalled-divider paths.

// File: rtl/flt_pkg.sv
// Shared definitions for the fast-lock window timer.
// Assumes a 2-bit mode field with the encoding listed below.
package flt_pkg;
    typedef enum logic [1:0] {
        FLM_OFF   = 2'b00,
        FLM_FAST  = 2'b01,
        FLM_PHASE = 2'b10,
        FLM_CONV  = 2'b11
    } flt_mode_e;
endpackage

// File: rtl/flt_cnt.sv
// Shared down counter for window length and free-running period.
// Assumes load has priority over counting; it stalls at zero.
module flt_cnt #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             en,
    output logic             tc,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    // Counter state: reload, count down on enable, hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (load)                  cnt_q <= load_val;
        else if (en && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end

    // Terminal count: the last enabled cycle of a period.
    always_comb begin
        zero = (cnt_q == '0);
        tc   = en && (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});
    end
endmodule

// File: rtl/flt_win.sv
// Window controller: opens on a qualifying register write, closes at
// terminal count or on mode exit, and tracks the zero-length error.
// Assumes tc is only meaningful while the window is open.
module flt_win (
    input  logic clk,
    input  logic rst_n,
    input  logic fast_mode,
    input  logic reg0_wr,
    input  logic len_zero,
    input  logic tc,
    output logic start,
    output logic active,
    output logic done,
    output logic err
);
    logic req;

    // Decode the start request and its refusal.
    always_comb begin
        req   = fast_mode && reg0_wr;
        start = req && !len_zero;
    end

    // Window state, expiry pulse and sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            done   <= 1'b0;
            err    <= 1'b0;
        end else begin
            done <= fast_mode && active && tc && !start;
            if (!fast_mode)      active <= 1'b0;
            else if (start)      active <= 1'b1;
            else if (tc)         active <= 1'b0;
            if (start)           err <= 1'b0;
            else if (req)        err <= 1'b1;
        end
    end
endmodule

// File: rtl/flt_free.sv
// Free-running sequencer for the phase-adjust and converter-clock modes.
// Requests a reload on mode entry, at terminal count or when stalled at
// zero, and registers one tick per completed period.
module flt_free (
    input  logic clk,
    input  logic rst_n,
    input  logic free_mode,
    input  logic tc,
    input  logic cnt_zero,
    output logic reload,
    output logic tick
);
    logic free_q;

    // Reload request for the shared counter.
    always_comb reload = free_mode && (!free_q || tc || cnt_zero);

    // Mode-entry history and registered period tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_q <= 1'b0;
            tick   <= 1'b0;
        end else begin
            free_q <= free_mode;
            tick   <= free_mode && free_q && tc;
        end
    end
endmodule

// File: rtl/flt_out.sv
// Output override: full-scale pump code and filter switch while the
// window is open. Assumes the switch needs the pin select at SW_SEL.
module flt_out #(
    parameter int          CP_W   = 4,
    parameter int          SEL_W  = 4,
    parameter logic [SEL_W-1:0] SW_SEL = 4'b1100
) (
    input  logic             active,
    input  logic [CP_W-1:0]  cp_prog,
    input  logic [SEL_W-1:0] mux_cfg,
    output logic [CP_W-1:0]  cp_code_eff,
    output logic             filt_short
);
    localparam logic [CP_W-1:0] CP_FULL = {CP_W{1'b1}};

    // Select forced or programmed code; gate the switch on the pin select.
    always_comb begin
        cp_code_eff = active ? CP_FULL : cp_prog;
        filt_short  = active && (mux_cfg == SW_SEL);
    end
endmodule

// File: rtl/fastlock_timer.sv
// Fast-lock bandwidth window timer with a shared terminal-count divider.
// Assumes pfd_tick is a one-clock strobe per phase-detector cycle and that
// reg0_wr is a one-clock pulse per write to the divider register.
module fastlock_timer #(
    parameter int CNT_W = 12,
    parameter int CP_W  = 4,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pfd_tick,
    input  logic [1:0]       mode_sel,
    input  logic             reg0_wr,
    input  logic [CNT_W-1:0] win_len,
    input  logic [CP_W-1:0]  cp_prog,
    input  logic [SEL_W-1:0] mux_cfg,
    output logic [CP_W-1:0]  cp_code_eff,
    output logic             filt_short,
    output logic             win_active,
    output logic             win_done,
    output logic             div_tc,
    output logic             len_err
);
    import flt_pkg::*;

    logic             fast_mode, free_mode, idle;
    logic             start, reload, tc, cnt_zero, len_zero;
    logic             cnt_load, cnt_en;
    logic [CNT_W-1:0] cnt_val;

    // Mode decode and shared-counter control.
    always_comb begin
        fast_mode = (flt_mode_e'(mode_sel) == FLM_FAST);
        free_mode = mode_sel[1];
        len_zero  = (win_len == '0);
        idle      = !win_active && !free_mode;
        cnt_en    = pfd_tick && (win_active || free_mode);
        cnt_load  = start || reload || idle;
        cnt_val   = (start || reload) ? win_len : '0;
    end

    flt_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val),
        .en(cnt_en), .tc(tc), .zero(cnt_zero)
    );

    flt_win u_win (
        .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode), .reg0_wr(reg0_wr),
        .len_zero(len_zero), .tc(tc), .start(start), .active(win_active),
        .done(win_done), .err(len_err)
    );

    flt_free u_free (
        .clk(clk), .rst_n(rst_n), .free_mode(free_mode), .tc(tc),
        .cnt_zero(cnt_zero), .reload(reload), .tick(div_tc)
    );

    flt_out #(.CP_W(CP_W), .SEL_W(SEL_W)) u_out (
        .active(win_active), .cp_prog(cp_prog), .mux_cfg(mux_cfg),
        .cp_code_eff(cp_code_eff), .filt_short(filt_short)
    );
endmodule

// File: rtl/fastlock_timer_chk.sv
// Port-level property checker for fastlock_timer, attached by bind.
module fastlock_timer_chk #(
    parameter int CNT_W = 12,
    parameter int CP_W  = 4,
    parameter int SEL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode_sel,
    input logic             reg0_wr,
    input logic [CNT_W-1:0] win_len,
    input logic [CP_W-1:0]  cp_code_eff,
    input logic [SEL_W-1:0] mux_cfg,
    input logic             filt_short,
    input logic             win_active,
    input logic             win_done,
    input logic             div_tc,
    input logic             len_err
);
    AST_OPEN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_active) |-> ($past(reg0_wr) && $past(mode_sel) == 2'b01)); // R2
    AST_FULL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_active) |-> cp_code_eff == {CP_W{1'b1}}); // R2
    AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> $fell(win_active)); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |=> !win_done); // R4
    AST_SWITCH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        filt_short |-> (mux_cfg == 4'b1100 && cp_code_eff == {CP_W{1'b1}})); // R5
    AST_ZERO_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg0_wr && mode_sel == 2'b01 && win_len == '0 && !win_active) |=> (!win_active && len_err)); // R7
    AST_MODE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (win_active && mode_sel != 2'b01) |=> (!win_active && !win_done)); // R8
    AST_TICK_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        div_tc |-> $past(mode_sel[1])); // R9
    AST_DONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> $past(mode_sel) == 2'b01); // R10
endmodule

bind fastlock_timer fastlock_timer_chk #(.CNT_W(CNT_W), .CP_W(CP_W), .SEL_W(SEL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .reg0_wr(reg0_wr),
    .win_len(win_len), .cp_code_eff(cp_code_eff), .mux_cfg(mux_cfg),
    .filt_short(filt_short), .win_active(win_active), .win_done(win_done),
    .div_tc(div_tc), .len_err(len_err)
);

// File: tb/fastlock_timer_tb.sv
module fastlock_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pfd_tick = 1'b0;
    logic [1:0]  mode_sel = 2'b00;
    logic        reg0_wr = 1'b0;
    logic [11:0] win_len = 12'd0;
    logic [3:0]  cp_prog = 4'd0;
    logic [3:0]  mux_cfg = 4'd0;
    logic [3:0]  cp_code_eff;
    logic        filt_short, win_active, win_done, div_tc, len_err;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    string phase = "R1";

    // Reference model state, derived from the requirements
    bit        m_act, m_done, m_err, m_tick, m_fr_prev;
    int        m_rem, m_ph;

    always #2.5 clk = ~clk;

    fastlock_timer u_dut (
        .clk(clk), .rst_n(rst_n), .pfd_tick(pfd_tick), .mode_sel(mode_sel),
        .reg0_wr(reg0_wr), .win_len(win_len), .cp_prog(cp_prog), .mux_cfg(mux_cfg),
        .cp_code_eff(cp_code_eff), .filt_short(filt_short), .win_active(win_active),
        .win_done(win_done), .div_tc(div_tc), .len_err(len_err)
    );

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_act = 0; m_done = 0; m_err = 0; m_tick = 0; m_fr_prev = 0;
            m_rem = 0; m_ph = 0;
        end else begin
            m_done = 0;
            m_tick = 0;
            if (mode_sel != 2'b01) m_act = 0;
            else if (reg0_wr && win_len != 0) begin
                m_act = 1; m_rem = int'(win_len); m_err = 0;
            end else begin
                if (reg0_wr) m_err = 1;
                if (m_act && pfd_tick) begin
                    m_rem--;
                    if (m_rem == 0) begin m_act = 0; m_done = 1; end
                end
            end
            if (mode_sel[1]) begin
                if (!m_fr_prev || m_ph == 0) m_ph = int'(win_len);
                else if (pfd_tick) begin
                    if (m_ph == 1) begin m_tick = 1; m_ph = int'(win_len); end
                    else m_ph--;
                end
            end
            m_fr_prev = mode_sel[1];
        end
        if (cyc >= 190000) begin
            fails++;
            $display("FAIL watchdog: got %0d cycles exp < 190000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s [%s] t=%0t: got %0h exp %0h", tag, phase, $time, got, exp);
        end
    endtask

    task automatic compare();
        chk("R3 win_active", int'(win_active), int'(m_act));
        chk("R2 cp_code_eff", int'(cp_code_eff), m_act ? 15 : int'(cp_prog));
        chk("R5 filt_short", int'(filt_short), int'(m_act && mux_cfg == 4'hC));
        chk("R4 win_done", int'(win_done), int'(m_done));
        chk("R7 len_err", int'(len_err), int'(m_err));
        chk("R9 div_tc", int'(div_tc), int'(m_tick));
    endtask

    // One cycle: sample at the falling edge, then apply new inputs.
    task automatic step(input bit tick, input bit wr, input logic [1:0] md,
                        input logic [11:0] len);
        @(negedge clk);
        compare();
        pfd_tick = tick; reg0_wr = wr; mode_sel = md; win_len = len;
        cp_prog = 4'($urandom % 16);
        mux_cfg = ($urandom % 3 == 0) ? 4'($urandom % 16) : 4'hC;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        cp_prog = 4'h5;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 active", int'(win_active), 0);
        chk("R1 code", int'(cp_code_eff), 5);
        chk("R1 flags", int'({filt_short, win_done, div_tc, len_err}), 0);

        phase = "R2 R3 R4 R5";
        for (int i = 0; i < 3000; i++)
            step($urandom % 2, ($urandom % 40) == 0, 2'b01, 12'(1 + $urandom % 15));
        phase = "R6";
        for (int i = 0; i < 2000; i++)
            step($urandom % 2, ($urandom % 6) == 0, 2'b01, 12'(5 + $urandom % 16));
        phase = "R7";
        for (int i = 0; i < 2000; i++)
            step($urandom % 2, ($urandom % 10) == 0, 2'b01, 12'($urandom % 4));
        phase = "R8";
        for (int i = 0; i < 3000; i++)
            step($urandom % 2, ($urandom % 5) == 0,
                 (($urandom % 12) == 0) ? 2'($urandom % 4) : mode_sel, 12'(1 + $urandom % 10));
        phase = "R9 R10";
        for (int i = 0; i < 4000; i++)
            step($urandom % 2, ($urandom % 5) == 0,
                 (($urandom % 300) == 0) ? 2'($urandom % 4) : (i < 2000 ? 2'b11 : 2'b10),
                 (($urandom % 150) == 0) ? 12'd0 : 12'(1 + $urandom % 6));
        phase = "R3 full length";
        step(1'b0, 1'b0, 2'b00, 12'd4095);
        step(1'b1, 1'b1, 2'b01, 12'd4095);
        for (int i = 0; i < 4100; i++) step(1'b1, 1'b0, 2'b01, 12'd4095);
        phase = "R3 length one";
        step(1'b1, 1'b1, 2'b01, 12'd1);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 2'b01, 12'd1);
        phase = "R9 zero period";
        for (int i = 0; i < 50; i++) step(1'b1, 1'b0, 2'b11, 12'd0);
        for (int i = 0; i < 50; i++) step(1'b1, 1'b0, 2'b11, 12'd3);
        @(negedge clk);
        compare();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule